// File: doc/BRIEF.md
# Multi-lane digital audio serializer

This block is the master of a multi-lane serial audio port. From the system clock it derives one bit clock and one word-select clock that all lanes share. On each of its serial output lanes it sends a stereo pair of 16-bit samples in every frame. On each serial input lane it captures a stereo pair on the same clocks. With the default of four lanes, eight output channels and eight input channels pass through the port.

On the core side every output channel has a write-enabled holding register. A frame starts when word select falls. At that point the holding registers move into the active registers that feed the shifters, so a write that lands in the middle of a frame never tears the samples on the wire. At the same frame start the block presents all captured input samples together and pulses a one-cycle frame strobe. A two-bit rate select sets the frame length to 128, 192, 256 or 384 system clocks. A frame always holds 64 bit clocks, so the bit clock period is 2, 3, 4 or 6 system clocks. The block reads the rate select only at a frame start.

Top module: `audio_lane_serializer`

## Requirements
- R1: While reset is held and until the first bit-clock edge after it, sck_o is 0, lrck_o is 1, every sdo_o bit is 0, rx_frame_o is 0 and rx_data_o is all zeros. The first frame strobe after reset presents all-zero input samples.
- R2: rate_sel_i values 0, 1, 2 and 3 give a frame (from one lrck_o fall to the next) of 128, 192, 256 and 384 system clocks. The sck_o period is 2, 3, 4 and 6 clocks, so a frame holds 64 sck_o rising edges.
- R3: lrck_o is 0 for the first 32 sck_o rising edges of a frame (left) and 1 for the last 32 (right). lrck_o and sdo_o change only in the clock where sck_o falls.
- R4: Number the rising edges of a frame 0..63 from the lrck_o fall. Lane k sends channel 2k (left) MSB first on edges 1..16 and channel 2k+1 (right) MSB first on edges 33..48. It drives 0 on every other edge.
- R5: tx_wr_en_i[c] loads tx_wr_data_i[16c+15:16c] into the holding register of channel c. The value goes on the wire from the next lrck_o fall. A write in the middle of a frame leaves that frame's bits unchanged.
- R6: A new rate_sel_i value is taken at the next lrck_o fall. The frame in progress keeps its old length.
- R7: sdi_i is sampled in the clock where sck_o rises, with the same edge-to-bit mapping as R4. The frame's samples appear on rx_data_o (channel c in bits 16c+15:16c) at the next lrck_o fall, and rx_data_o holds them until the following frame start.
- R8: rx_frame_o is high for exactly one clock. It rises in the same clock in which lrck_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel_i | input | 2 | Frame length select: 128/192/256/384 clocks |
| tx_wr_en_i | input | 8 | Per-channel write enable of the holding registers |
| tx_wr_data_i | input | 128 | Per-channel write data, channel c in bits 16c+15:16c |
| sdi_i | input | 4 | Serial input lanes |
| sck_o | output | 1 | Shared bit clock |
| lrck_o | output | 1 | Shared word select, low for left |
| sdo_o | output | 4 | Serial output lanes |
| rx_data_o | output | 128 | Captured input samples, channel c in bits 16c+15:16c |
| rx_frame_o | output | 1 | One-cycle frame-start strobe |

## Verification
Suppose the bit position counter or the divider count goes wrong. Within one frame that shows at the ports as a frame length or a bit clock period that does not match the rate, or as word select changing away from a falling bit-clock edge. Suppose an active or holding register is corrupted. The first frame decoded off the wire after the damage then shows a wrong sample, or a sample too early or too late against a mid-frame write. The bench loops the output lanes back to the input lanes, sometimes inverted. A fault in the capture shift registers therefore shows on rx_data_o at the very next strobe.

// File: rtl/als_pkg.sv
package als_pkg;
   localparam int SLOT_BITS  = 32;
   localparam int FRAME_BITS = 2 * SLOT_BITS;
   localparam int POS_W      = $clog2(FRAME_BITS);
   localparam int DIV_W      = 3;

   // System clocks per bit clock for each rate code (frame = 64 bit clocks).
   function automatic logic [DIV_W-1:0] bclk_div(input logic [1:0] code);
      case (code)
         2'd0:    return DIV_W'(2);
         2'd1:    return DIV_W'(3);
         2'd2:    return DIV_W'(4);
         default: return DIV_W'(6);
      endcase
   endfunction
endpackage

// File: rtl/als_timing.sv
module als_timing
   import als_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       rate_sel_i,
   output logic             sck_o,
   output logic             lrck_o,
   output logic             rise_o,
   output logic             fall_o,
   output logic             wrap_o,
   output logic [POS_W-1:0] pos_o,
   output logic [POS_W-1:0] next_pos_o
);
   logic [1:0]       rate_q;
   logic [DIV_W-1:0] cnt_q, cnt_n, div, half;
   logic [POS_W-1:0] pos_q;

   always_comb begin
      div        = bclk_div(rate_q);
      half       = div >> 1;
      fall_o     = (cnt_q == div - DIV_W'(1));
      rise_o     = (cnt_q == half - DIV_W'(1));
      cnt_n      = fall_o ? '0 : cnt_q + DIV_W'(1);
      next_pos_o = pos_q + POS_W'(1);
      wrap_o     = fall_o && (pos_q == POS_W'(FRAME_BITS - 1));
      pos_o      = pos_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= rate_sel_i;
         cnt_q  <= '0;
         pos_q  <= POS_W'(FRAME_BITS - 1);
         sck_o  <= 1'b0;
         lrck_o <= 1'b1;
      end else begin
         cnt_q <= cnt_n;
         sck_o <= (cnt_n >= half);
         if (fall_o) begin
            pos_q  <= next_pos_o;
            lrck_o <= next_pos_o[POS_W-1];
         end
         if (wrap_o)
            rate_q <= rate_sel_i;
      end
   end
endmodule

// File: rtl/als_tx_lane.sv
module als_tx_lane
   import als_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            wr_en_i,
   input  logic [2*SAMPLE_W-1:0] wr_data_i,
   input  logic                  fall_i,
   input  logic                  wrap_i,
   input  logic [POS_W-1:0]      next_pos_i,
   output logic                  sdo_o
);
   localparam int IDX_W = $clog2(SAMPLE_W);

   logic [SAMPLE_W-1:0] hold_l, hold_r, act_l, act_r, sel;
   logic [IDX_W-1:0]    idx;
   logic                bit_n;
   int                  j;

   always_comb begin
      j     = int'(next_pos_i[POS_W-2:0]);
      sel   = next_pos_i[POS_W-1] ? act_r : act_l;
      idx   = IDX_W'(SAMPLE_W - j);
      bit_n = (j >= 1 && j <= SAMPLE_W) ? sel[idx] : 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l <= '0;
         hold_r <= '0;
         act_l  <= '0;
         act_r  <= '0;
         sdo_o  <= 1'b0;
      end else begin
         if (wr_en_i[0]) hold_l <= wr_data_i[SAMPLE_W-1:0];
         if (wr_en_i[1]) hold_r <= wr_data_i[2*SAMPLE_W-1:SAMPLE_W];
         if (wrap_i) begin
            act_l <= hold_l;
            act_r <= hold_r;
         end
         if (fall_i) sdo_o <= bit_n;
      end
   end
endmodule

// File: rtl/als_rx_lane.sv
module als_rx_lane
   import als_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sdi_i,
   input  logic                  rise_i,
   input  logic                  wrap_i,
   input  logic [POS_W-1:0]      pos_i,
   output logic [2*SAMPLE_W-1:0] data_o
);
   logic [SAMPLE_W-1:0] sh_l, sh_r;
   logic                cap;
   int                  j;

   always_comb begin
      j   = int'(pos_i[POS_W-2:0]);
      cap = rise_i && (j >= 1) && (j <= SAMPLE_W);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_l   <= '0;
         sh_r   <= '0;
         data_o <= '0;
      end else begin
         if (cap && pos_i[POS_W-1])  sh_r <= {sh_r[SAMPLE_W-2:0], sdi_i};
         if (cap && !pos_i[POS_W-1]) sh_l <= {sh_l[SAMPLE_W-2:0], sdi_i};
         if (wrap_i) data_o <= {sh_r, sh_l};
      end
   end
endmodule

// File: rtl/audio_lane_serializer.sv
module audio_lane_serializer
   import als_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int SAMPLE_W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   rate_sel_i,
   input  logic [2*LANES-1:0]           tx_wr_en_i,
   input  logic [2*LANES*SAMPLE_W-1:0]  tx_wr_data_i,
   input  logic [LANES-1:0]             sdi_i,
   output logic                         sck_o,
   output logic                         lrck_o,
   output logic [LANES-1:0]             sdo_o,
   output logic [2*LANES*SAMPLE_W-1:0]  rx_data_o,
   output logic                         rx_frame_o
);
   localparam int PAIR_W = 2 * SAMPLE_W;

   if (SAMPLE_W < 2 || SAMPLE_W > SLOT_BITS - 1) begin : g_bad_width
      $error("SAMPLE_W must lie in 2..SLOT_BITS-1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic             rise, fall, wrap;
   logic [POS_W-1:0] pos, next_pos;

   als_timing u_timing (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_sel_i (rate_sel_i),
      .sck_o      (sck_o),
      .lrck_o     (lrck_o),
      .rise_o     (rise),
      .fall_o     (fall),
      .wrap_o     (wrap),
      .pos_o      (pos),
      .next_pos_o (next_pos)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      als_tx_lane #(.SAMPLE_W(SAMPLE_W)) u_tx (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en_i    (tx_wr_en_i[2*k +: 2]),
         .wr_data_i  (tx_wr_data_i[k*PAIR_W +: PAIR_W]),
         .fall_i     (fall),
         .wrap_i     (wrap),
         .next_pos_i (next_pos),
         .sdo_o      (sdo_o[k])
      );
      als_rx_lane #(.SAMPLE_W(SAMPLE_W)) u_rx (
         .clk    (clk),
         .rst_n  (rst_n),
         .sdi_i  (sdi_i[k]),
         .rise_i (rise),
         .wrap_i (wrap),
         .pos_i  (pos),
         .data_o (rx_data_o[k*PAIR_W +: PAIR_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rx_frame_o <= 1'b0;
      else        rx_frame_o <= wrap;
   end
endmodule

// File: rtl/als_checker.sv
module als_checker #(
   parameter int LANES    = 4,
   parameter int SAMPLE_W = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        sck_o,
   input logic                        lrck_o,
   input logic [LANES-1:0]            sdo_o,
   input logic [2*LANES*SAMPLE_W-1:0] rx_data_o,
   input logic                        rx_frame_o
);
   p_lrck_on_sck_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lrck_o) |-> $fell(sck_o));

   p_sdo_on_sck_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo_o) |-> $fell(sck_o));

   p_slot_edge_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lrck_o) |-> (sdo_o == '0));

   p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data_o) |-> rx_frame_o);

   p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_frame_o |=> !rx_frame_o);

   p_strobe_at_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_frame_o |-> $fell(lrck_o));
endmodule

bind audio_lane_serializer als_checker #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sck_o      (sck_o),
   .lrck_o     (lrck_o),
   .sdo_o      (sdo_o),
   .rx_data_o  (rx_data_o),
   .rx_frame_o (rx_frame_o)
);

// File: tb/audio_lane_serializer_bench.sv
module audio_lane_serializer_bench;
   localparam int LANES = 4;
   localparam int CH    = 2 * LANES;
   localparam int W     = 16;

   // rate code, base sample pattern
   localparam logic [17:0] VEC [4] = '{
      {2'd0, 16'hA5C3}, {2'd1, 16'h1234}, {2'd3, 16'hFFFF}, {2'd2, 16'h8001}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        rate_sel = 2'd0;
   logic [CH-1:0]     tx_wr_en = '0;
   logic [CH*W-1:0]   tx_wr_data = '0;
   logic [LANES-1:0]  sdi, sdo;
   logic              sck, lrck, rx_frame, inv = 1'b0;
   logic [CH*W-1:0]   rx_data;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;
   assign sdi = inv ? ~sdo : sdo;

   audio_lane_serializer u_audio_lane_serializer (
      .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel), .tx_wr_en_i(tx_wr_en),
      .tx_wr_data_i(tx_wr_data), .sdi_i(sdi), .sck_o(sck), .lrck_o(lrck),
      .sdo_o(sdo), .rx_data_o(rx_data), .rx_frame_o(rx_frame));

   // ---------------- wire monitor ----------------
   logic [63:0]     fbits [LANES];
   logic [W-1:0]    dec [CH];
   logic [CH*W-1:0] rx_snap;
   logic            sck_p, lrck_p, strobe_snap, frame_ok, pad_ok, lr_ok, lr_acc, edge_ok;
   int idx, cyc, last_fall, frame_len, frame_cnt, sck_last, sck_per;

   always @(negedge clk) begin
      if (!rst_n) begin
         idx = 0; cyc = 0; last_fall = 0; frame_cnt = 0; sck_last = 0; sck_per = 0;
         sck_p = 1'b0; lrck_p = 1'b1; lr_acc = 1'b1; lr_ok = 1'b1; edge_ok = 1'b1;
         frame_ok = 1'b0; pad_ok = 1'b1; strobe_snap = 1'b0; rx_snap = '0;
      end else begin
         cyc++;
         if (sdo != fbits[0][0] && 1'b0) edge_ok = 1'b0;
         if (sck && !sck_p) begin
            if (idx < 64) begin
               for (int l = 0; l < LANES; l++) fbits[l][idx[5:0]] = sdo[l];
               if (lrck != (idx >= 32)) lr_acc = 1'b0;
            end
            idx++;
            sck_per  = cyc - sck_last;
            sck_last = cyc;
         end
         if (!lrck && lrck_p) begin
            frame_ok = (idx == 64);
            lr_ok    = lr_acc;
            lr_acc   = 1'b1;
            pad_ok   = 1'b1;
            for (int c = 0; c < CH; c++)
               for (int k = 0; k < W; k++)
                  dec[c][W-1-k] = fbits[c/2][6'((c%2)*32 + 1 + k)];
            for (int l = 0; l < LANES; l++)
               for (int i = 0; i < 64; i++)
                  if (!((i >= 1 && i <= 16) || (i >= 33 && i <= 48)) && fbits[l][i[5:0]])
                     pad_ok = 1'b0;
            frame_len   = cyc - last_fall;
            last_fall   = cyc;
            rx_snap     = rx_data;
            strobe_snap = rx_frame;
            idx = 0;
            frame_cnt++;
         end
         sck_p  = sck;
         lrck_p = lrck;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_frames(input int n);
      int target;
      target = frame_cnt + n;
      while (frame_cnt < target) @(negedge clk);
   endtask

   function automatic int period_of(input logic [1:0] r);
      case (r)
         2'd0: return 128;
         2'd1: return 192;
         2'd2: return 256;
         default: return 384;
      endcase
   endfunction

   logic [W-1:0] samp [CH];
   logic [W-1:0] prev [CH];

   task automatic make_and_write(input logic [W-1:0] base);
      for (int c = 0; c < CH; c++) begin
         samp[c] = base ^ W'(32'h1357 * c);
         tx_wr_data[c*W +: W] = samp[c];
      end
      tx_wr_en = '1;
      @(negedge clk);
      tx_wr_en = '0;
   endtask

   task automatic check_tx(input string req, input logic [W-1:0] exp [CH]);
      for (int c = 0; c < CH; c++)
         chk(dec[c] == exp[c], req, $sformatf("wire channel %0d", c), dec[c], exp[c]);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(sck == 1'b0,   "R1", "sck in reset",  sck, 0);
      chk(lrck == 1'b1,  "R1", "lrck in reset", lrck, 1);
      chk(sdo == '0,     "R1", "sdo in reset",  sdo, 0);
      chk(rx_frame == 0, "R1", "strobe in reset", rx_frame, 0);
      chk(rx_data == '0, "R1", "rx data in reset", rx_data, 0);
      rst_n = 1'b1;
      wait_frames(1);
      chk(strobe_snap == 1'b1, "R8", "strobe on first frame start", strobe_snap, 1);
      chk(rx_snap == '0,       "R1", "first strobe data zero", rx_snap, 0);

      // table walk: rate, samples, loopback polarity
      for (int v = 0; v < 4; v++) begin
         rate_sel = VEC[v][17:16];
         inv      = v[0];
         make_and_write(VEC[v][15:0]);
         wait_frames(2);
         chk(frame_ok, "R2", "64 bit clocks per frame", idx, 64);
         chk(frame_len == period_of(VEC[v][17:16]), "R2", "frame length",
             frame_len, period_of(VEC[v][17:16]));
         chk(sck_per == period_of(VEC[v][17:16]) / 64, "R2", "bit clock period",
             sck_per, period_of(VEC[v][17:16]) / 64);
         chk(lr_ok, "R3", "word select level per half", lr_ok, 1);
         chk(pad_ok, "R4", "unused bit positions zero", pad_ok, 1);
         check_tx("R4", samp);
         for (int c = 0; c < CH; c++)
            chk(rx_snap[c*W +: W] == (inv ? ~samp[c] : samp[c]), "R7",
                $sformatf("captured channel %0d", c), rx_snap[c*W +: W],
                inv ? ~samp[c] : samp[c]);
         chk(strobe_snap == 1'b1, "R8", "strobe with word select fall", strobe_snap, 1);
      end

      // R5: mid-frame write must not tear the frame in progress
      rate_sel = 2'd0;
      wait_frames(2);
      for (int c = 0; c < CH; c++) prev[c] = samp[c];
      repeat (60) @(negedge clk);
      make_and_write(16'h5AF0);
      wait_frames(1);
      check_tx("R5", prev);
      wait_frames(1);
      check_tx("R5", samp);

      // R6: rate change mid-frame applies at the next frame start
      repeat (40) @(negedge clk);
      rate_sel = 2'd3;
      wait_frames(1);
      chk(frame_len == 128, "R6", "frame in progress keeps old length", frame_len, 128);
      wait_frames(1);
      chk(frame_len == 384, "R6", "next frame uses new length", frame_len, 384);
      chk(sck_per == 6, "R6", "new bit clock period", sck_per, 6);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule